// File: doc/BRIEF.md
# Keyed Subsystem Reset Register

This block is a 32-bit control register on a simple register bus that lets software reset a whole storage subsystem built from several controllers. It watches writes to its own address and acts only on one exact 32-bit key, `32'h4E564D65` (the ASCII characters "NVMe"), written with all four byte lanes enabled. Any other value, a partial-lane write, or a write to another address does nothing. The key register always reads back as zero.

When the key is accepted, the block raises one reset line per controller, all together. Every line stays high for at least `MIN_CYC` cycles and until every controller has returned a done pulse. Done pulses are remembered from the first cycle of the sequence, so a controller that finishes early is not missed. While a sequence runs, `busy` is high and further key writes are ignored. When the sequence ends, a sticky status bit is set. Software reads that bit at a second address and clears it by writing 1 to bit 0 there.

Top module: `subsys_reset_reg`

## Requirements
- R1: After synchronous reset, all `ctrl_rst` bits, `busy`, `rd_data` and the status bit are 0.
- R2: A write to `KEY_ADDR` with `wr_data == 32'h4E564D65` and `wr_be == 4'hF`, accepted at a rising edge, drives `busy` and every bit of `ctrl_rst` high from that edge on.
- R3: A write to `KEY_ADDR` with any other data value, or the key written to any other address, leaves `busy` and `ctrl_rst` low.
- R4: A key write whose `wr_be` is anything other than `4'hF` never starts a reset.
- R5: A read of `KEY_ADDR` returns zero in `rd_data` one cycle after `rd_en`, whatever was written before. Reads of unmapped addresses also return zero.
- R6: Once started, `ctrl_rst` stays high for at least `MIN_CYC` cycles.
- R7: `ctrl_rst` stays high until every controller has pulsed its `ctrl_done` bit during the sequence. The high time is max(`MIN_CYC`, L) cycles, where L is the cycle (1-based after the start edge) of the last done pulse.
- R8: A key write while `busy` is high neither restarts nor lengthens the sequence.
- R9: When a sequence ends, the status bit is set. It reads as bit 0 of `rd_data` at `STAT_ADDR`, one cycle after `rd_en`.
- R10: Writing to `STAT_ADDR` with bit 0 of `wr_data` at 1 and `wr_be[0]` at 1 clears the status bit. Writing 0 to bit 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid one cycle after `rd_en` |
| ctrl_done | input | N_CTRL | Per-controller completion pulse |
| ctrl_rst | output | N_CTRL | Per-controller reset request |
| busy | output | 1 | High while a subsystem reset is in progress |

## Verification
The key write is sampled at a rising edge, and `busy`/`ctrl_rst` are high from that edge on. The bench therefore samples them at the following falling edge. It counts the falling edges on which `ctrl_rst` is high and compares that count with max(`MIN_CYC`, L), where each done pulse is driven at the falling edge inside its chosen cycle. Read data is due one edge after `rd_en`, so each read samples `rd_data` at the next falling edge. Single-bit corruptions of the key and all partial byte-enable patterns are swept. `busy` is checked one cycle later each time.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam logic [31:0] RESET_KEY = 32'h4E564D65;
    localparam logic [3:0]  FULL_BE   = 4'hF;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic        wr;
        logic [31:0] data;
        logic [3:0]  be;
    } bus_write_t;

    function automatic logic key_ok(input bus_write_t w);
        return w.wr && (w.be == FULL_BE) && (w.data == RESET_KEY);
    endfunction

endpackage

// File: rtl/ssr_key_match.sv
module ssr_key_match
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_write_t        wr,
    input  logic              busy,
    output logic              trigger
);
    always_comb begin
        trigger = (addr == KEY_ADDR) && key_ok(wr) && !busy;
    end
endmodule

// File: rtl/ssr_ack_collect.sv
module ssr_ack_collect #(
    parameter int N_CTRL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              track,
    input  logic [N_CTRL-1:0] done_in,
    output logic              all_seen
);
    logic [N_CTRL-1:0] seen_q;
    logic [N_CTRL-1:0] seen_now;

    for (genvar i = 0; i < N_CTRL; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                seen_q[i] <= 1'b0;
            end else if (track && done_in[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
        assign seen_now[i] = seen_q[i] || (track && done_in[i]);
    end

    assign all_seen = &seen_now;

    assert_seen_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (track && !clear && done_in[0]) |=> seen_q[0]);
endmodule

// File: rtl/ssr_seq.sv
module ssr_seq
    import ssr_pkg::*;
#(
    parameter int MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    input  logic all_seen,
    output logic busy,
    output logic release_p
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             min_met;

    assign min_met   = (cnt_q == LAST);
    assign busy      = (state_q == SEQ_HOLD);
    assign release_p = busy && min_met && all_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (trigger) begin
                    state_q <= SEQ_HOLD;
                    cnt_q   <= '0;
                end
                SEQ_HOLD: begin
                    if (release_p) state_q <= SEQ_IDLE;
                    if (!min_met)  cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assert_min_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !min_met) |=> busy);
    assert_ack_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !all_seen) |=> busy);
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/subsys_reset_reg.sv
module subsys_reset_reg
    import ssr_pkg::*;
#(
    parameter int N_CTRL = 4,
    parameter int MIN_CYC = 8,
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [N_CTRL-1:0] ctrl_done,
    output logic [N_CTRL-1:0] ctrl_rst,
    output logic              busy
);
    bus_write_t wr;
    logic       trigger;
    logic       all_seen;
    logic       release_p;
    logic       status_q;
    logic       stat_clr;

    assign wr = '{wr: wr_en, data: wr_data, be: wr_be};

    ssr_key_match #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR)) u_match (
        .addr(addr), .wr(wr), .busy(busy), .trigger(trigger)
    );

    ssr_ack_collect #(.N_CTRL(N_CTRL)) u_acks (
        .clk(clk), .rst(rst), .clear(trigger), .track(busy),
        .done_in(ctrl_done), .all_seen(all_seen)
    );

    ssr_seq #(.MIN_CYC(MIN_CYC)) u_seq (
        .clk(clk), .rst(rst), .trigger(trigger), .all_seen(all_seen),
        .busy(busy), .release_p(release_p)
    );

    for (genvar i = 0; i < N_CTRL; i++) begin : g_fan
        assign ctrl_rst[i] = busy;
    end

    assign stat_clr = wr_en && (addr == STAT_ADDR) && wr_be[0] && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else if (release_p) begin
            status_q <= 1'b1;
        end else if (stat_clr) begin
            status_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en && (addr == STAT_ADDR)) begin
            rd_data <= {31'b0, status_q};
        end else begin
            rd_data <= '0;
        end
    end

    assert_start_on_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && addr == KEY_ADDR && wr_be == FULL_BE
                              && wr_data == RESET_KEY));
    assert_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en) && $past(addr) == KEY_ADDR) |-> (rd_data == 32'd0));
    assert_status_set_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status_q);
    assert_status_clear_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_clr) && !$past(release_p)) |-> !status_q);
endmodule

// File: tb/subsys_reset_reg_tb.sv
module subsys_reset_reg_tb;
    localparam int N_CTRL = 4;
    localparam int MIN_CYC = 8;
    localparam logic [7:0] KEY_A  = 8'h20;
    localparam logic [7:0] STAT_A = 8'h24;
    localparam logic [31:0] KEY   = 32'h4E564D65;

    logic clk = 1'b0;
    logic rst;
    logic [7:0] addr;
    logic wr_en;
    logic [31:0] wr_data;
    logic [3:0] wr_be;
    logic rd_en;
    logic [31:0] rd_data;
    logic [N_CTRL-1:0] ctrl_done;
    logic [N_CTRL-1:0] ctrl_rst;
    logic busy;

    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    subsys_reset_reg #(.N_CTRL(N_CTRL), .MIN_CYC(MIN_CYC)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_data(rd_data),
        .ctrl_done(ctrl_done), .ctrl_rst(ctrl_rst), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        addr = a; wr_data = d; wr_be = be; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Runs one reset: last controller acks in cycle last_ack; optional key write in cycle 2.
    task automatic run_seq(input int last_ack, input bit poke, output int hi_cycles);
        int ack_at[N_CTRL];
        for (int i = 0; i < N_CTRL; i++) ack_at[i] = 1 + (i * last_ack) / N_CTRL;
        ack_at[N_CTRL-1] = last_ack;
        @(negedge clk);
        addr = KEY_A; wr_data = KEY; wr_be = 4'hF; wr_en = 1'b1;
        hi_cycles = 0;
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            wr_en = (poke && k == 2);
            for (int i = 0; i < N_CTRL; i++) ctrl_done[i] = (ack_at[i] == k);
            if (ctrl_rst != {N_CTRL{1'b1}}) begin
                chk(ctrl_rst == '0, "R2 lines move together", ctrl_rst, 0);
                break;
            end
            hi_cycles++;
        end
        ctrl_done = '0;
        wr_en = 1'b0;
    endtask

    initial begin
        int watchdog = 0;
        while (watchdog < 100000) begin
            @(posedge clk);
            watchdog++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000", watchdog);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int hi;
        int exp;
        rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0; wr_be = '0;
        rd_en = 1'b0; ctrl_done = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_rst == '0 && !busy, "R1 outputs idle", {ctrl_rst, busy}, 0);
        chk(rd_data == 0, "R1 rd_data", rd_data, 0);
        do_read(STAT_A, rd);
        chk(rd == 0, "R1 status clear", rd, 0);

        // R3 single-bit corrupted keys
        for (int b = 0; b < 32; b++) begin
            do_write(KEY_A, KEY ^ (32'd1 << b), 4'hF);
            chk(!busy && ctrl_rst == '0, "R3 near-key ignored", busy, 0);
        end
        do_write(8'h00, KEY, 4'hF);
        chk(!busy, "R3 key at other address", busy, 0);
        do_write(STAT_A, KEY, 4'hF);
        chk(!busy, "R3 key at status address", busy, 0);

        // R4 every partial byte enable
        for (int be = 0; be < 15; be++) begin
            do_write(KEY_A, KEY, be[3:0]);
            chk(!busy, "R4 partial lanes ignored", be, 0);
        end

        // R5 key register reads zero after writes
        do_write(KEY_A, 32'hFFFF_FFFF, 4'hF);
        do_read(KEY_A, rd);
        chk(rd == 0, "R5 key reads zero", rd, 0);
        do_read(8'h10, rd);
        chk(rd == 0, "R5 unmapped reads zero", rd, 0);

        // R2/R6/R7 ack timing sweep
        for (int L = 1; L <= 12; L++) begin
            run_seq(L, 1'b0, hi);
            exp = (L > MIN_CYC) ? L : MIN_CYC;
            chk(hi == exp, "R6/R7 hold length", hi, exp);
        end
        chk(!busy, "R2 busy drops after sequence", busy, 0);

        // R5 during/after reset: key still reads zero
        do_read(KEY_A, rd);
        chk(rd == 0, "R5 key reads zero after reset", rd, 0);

        // R8 key write while busy
        run_seq(5, 1'b1, hi);
        chk(hi == MIN_CYC, "R8 busy key ignored (min)", hi, MIN_CYC);
        run_seq(11, 1'b1, hi);
        chk(hi == 11, "R8 busy key ignored (ack)", hi, 11);
        @(negedge clk);
        chk(!busy, "R8 no restart afterwards", busy, 0);

        // R9 / R10 status
        do_read(STAT_A, rd);
        chk(rd == 1, "R9 status set", rd, 1);
        do_write(STAT_A, 32'h0, 4'hF);
        do_read(STAT_A, rd);
        chk(rd == 1, "R10 write 0 keeps status", rd, 1);
        do_write(STAT_A, 32'h1, 4'hE);
        do_read(STAT_A, rd);
        chk(rd == 1, "R10 lane 0 disabled keeps status", rd, 1);
        do_write(STAT_A, 32'h1, 4'h1);
        do_read(STAT_A, rd);
        chk(rd == 0, "R10 write 1 clears status", rd, 0);

        // R1 again: reset in mid-sequence
        @(negedge clk);
        addr = KEY_A; wr_data = KEY; wr_be = 4'hF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy, "R2 started", busy, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && ctrl_rst == '0, "R1 reset aborts", busy, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule